// File: doc/BRIEF.md
# Adaptive-Threshold Bit-Flipping LDPC Decoder

This block corrects bit errors in a hard-decision word read from a storage medium. The word is protected by a small binary LDPC code with a fixed sparse parity-check matrix, and the decoder works on hard bits only. It accepts one word through a valid/ready load port. It then iterates at one iteration per clock cycle. In each iteration it evaluates every parity check and counts, for every bit, how many of that bit's checks fail. Every bit whose count is at or above the current threshold is inverted in the same cycle. No search for the largest count is ever made.

The threshold adapts between iterations. It starts at the column weight. It drops by one when an iteration inverted nothing while checks still fail, so that more suspect bits can flip together. It rises by one when an iteration inverted more than a set limit of bits, which protects correct bits from being wrongly inverted. Decoding ends with success once every check holds. It ends with failure once a programmable iteration budget is used up. The result stays on the output until the next word is accepted.

The control is a three-state machine. `S_IDLE` is the reset state. It moves to `S_RUN` on an accepted load. `S_RUN` is a flip-and-adapt iteration each cycle, and it leaves to `S_DONE` on success or when the budget runs out. `S_DONE` presents the result and goes back to `S_RUN` on the next accepted load.

Top module: `ldpc_bf_decoder`

## Requirements
- R1: `in_ready` is low only in `S_RUN`. A load is accepted when `in_valid` and `in_ready` are both high at a clock edge. In the next cycle the machine is in `S_RUN` with `out_valid` low, `out_iters` 0 and `cur_thresh` 3, whatever the earlier decode left behind.
- R2: The code has length 25, with 15 checks and column weight 3. Bit n = 5j+t (j in 0..4, t in 0..4) belongs to the checks 5i + ((t + i*j) mod 5) for i = 0, 1, 2. A word that satisfies all 15 checks ends with `out_ok` = 1, `out_iters` = 0 and the word unchanged, on the second edge after acceptance.
- R3: A bit's metric is the number of its failing checks (0..3). In each `S_RUN` cycle that does not end decoding, every bit whose metric is at or above `cur_thresh` is inverted at once, and `out_iters` increments. A codeword with a single inverted bit is restored in exactly one iteration (`out_iters` = 1).
- R4: If an iteration inverts no bit while a check still fails, the threshold falls by 1, but not below 1. Two errors at bits 0 and 5 (they share check 0) give `cur_thresh` 2 and `out_iters` 1 after the first iteration.
- R5: If an iteration inverts more than 6 bits, the threshold rises by 1, but not above 3. The all-ones word fails every check, so all 25 bits invert, the threshold stays 3, and the decode ends with the all-zero word, `out_ok` = 1 and `out_iters` = 1.
- R6: When `out_iters` equals the `max_iter` value captured at load and a check still fails, decoding ends with `out_ok` = 0 and the word as it stands. With `max_iter` = 0 a corrupted word is returned unchanged with `out_iters` 0.
- R7: `out_valid` stays high, with `out_word`, `out_ok` and `out_iters` steady, until the next accepted load.
- R8: Whenever `out_ok` is 1, `out_word` satisfies all checks of R2, and `out_iters` never exceeds the captured `max_iter`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Load request |
| in_ready | output | 1 | Decoder can accept a word |
| in_word | input | 25 | Hard-decision received word |
| max_iter | input | 8 | Iteration budget, captured at load |
| out_valid | output | 1 | Result available |
| out_ok | output | 1 | All checks satisfied |
| out_word | output | 25 | Current or final word |
| out_iters | output | 8 | Flip iterations performed |
| cur_thresh | output | 2 | Current flipping threshold |

## Verification
The bench loads clean codewords, single-error words and words with random two- and three-bit errors, all built by its own encoder. It aims at the threshold edges. With the pair at bits 0 and 5 no metric reaches 3, so a design that never lowers the threshold stalls and runs out its budget. The all-ones word makes every bit flip, so a missing ceiling would push the threshold past the column weight. Budgets of 0 and 1 expose off-by-one termination, which shows up as an extra flip or a wrong count. A second load after a finished decode shows whether the threshold and the counter are really reset.

// File: rtl/ldpc_pkg.sv
package ldpc_pkg;
    localparam int P    = 5;            // circulant size
    localparam int J    = 3;            // column weight
    localparam int L    = 5;            // row weight (block columns)
    localparam int N    = P * L;        // code length
    localparam int M    = P * J;        // number of checks
    localparam int CW   = $clog2(J + 1);
    localparam int NW   = $clog2(N + 1);
    localparam int ITW  = 8;
    localparam int FLIP_LIMIT = N / 4;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_DONE = 2'd2
    } dec_state_e;

    // Check index of the i-th connection of bit n (array-code structure)
    function automatic int check_of(input int n, input int i);
        return i * P + (((n % P) + i * (n / P)) % P);
    endfunction
endpackage

// File: rtl/ldpc_syndrome.sv
module ldpc_syndrome
    import ldpc_pkg::*;
(
    input  logic [N-1:0] word,
    output logic [M-1:0] syn
);
    for (genvar m = 0; m < M; m++) begin : g_chk
        always_comb begin
            logic acc;
            acc = 1'b0;
            for (int n = 0; n < N; n++) begin
                if (check_of(n, m / P) == m)
                    acc = acc ^ word[n];
            end
            syn[m] = acc;
        end
    end
endmodule

// File: rtl/ldpc_metric.sv
module ldpc_metric
    import ldpc_pkg::*;
(
    input  logic [M-1:0]  syn,
    input  logic [CW-1:0] thr,
    output logic [N-1:0]  flip,
    output logic [NW-1:0] nflip
);
    for (genvar n = 0; n < N; n++) begin : g_bit
        logic [CW-1:0] cnt;
        always_comb begin
            cnt = '0;
            for (int i = 0; i < J; i++)
                cnt = cnt + CW'(syn[check_of(n, i)]);
        end
        assign flip[n] = (cnt >= thr);
    end

    always_comb begin
        nflip = '0;
        for (int n = 0; n < N; n++)
            nflip = nflip + NW'(flip[n]);
    end
endmodule

// File: rtl/ldpc_thresh.sv
module ldpc_thresh
    import ldpc_pkg::*;
(
    input  logic [CW-1:0] thr,
    input  logic [NW-1:0] nflip,
    output logic [CW-1:0] thr_next
);
    always_comb begin
        thr_next = thr;
        if (nflip == '0) begin
            if (thr > CW'(1))
                thr_next = thr - CW'(1);
        end else if (nflip > NW'(FLIP_LIMIT)) begin
            if (thr < CW'(J))
                thr_next = thr + CW'(1);
        end
    end
endmodule

// File: rtl/ldpc_bf_decoder.sv
module ldpc_bf_decoder
    import ldpc_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [N-1:0]   in_word,
    input  logic [ITW-1:0] max_iter,
    output logic           out_valid,
    output logic           out_ok,
    output logic [N-1:0]   out_word,
    output logic [ITW-1:0] out_iters,
    output logic [CW-1:0]  cur_thresh
);
    dec_state_e     state, state_nxt;
    logic [N-1:0]   word_q;
    logic [ITW-1:0] iter_q, limit_q;
    logic [CW-1:0]  thr_q, thr_nxt;
    logic           ok_q;
    logic [M-1:0]   syn;
    logic [N-1:0]   flip;
    logic [NW-1:0]  nflip;
    logic           accept, syn_zero, budget_out;

    ldpc_syndrome u_syn (.word(word_q), .syn(syn));
    ldpc_metric   u_met (.syn(syn), .thr(thr_q), .flip(flip), .nflip(nflip));
    ldpc_thresh   u_thr (.thr(thr_q), .nflip(nflip), .thr_next(thr_nxt));

    assign in_ready   = (state != S_RUN);
    assign accept     = in_valid && in_ready;
    assign syn_zero   = (syn == '0);
    assign budget_out = (iter_q == limit_q);

    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE:  if (accept) state_nxt = S_RUN;
            S_RUN:   if (syn_zero || budget_out) state_nxt = S_DONE;
            S_DONE:  if (accept) state_nxt = S_RUN;
            default: state_nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q  <= '0;
            iter_q  <= '0;
            limit_q <= '0;
            thr_q   <= CW'(J);
            ok_q    <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE, S_DONE: begin
                    if (accept) begin
                        word_q  <= in_word;
                        limit_q <= max_iter;
                        iter_q  <= '0;
                        thr_q   <= CW'(J);
                        ok_q    <= 1'b0;
                    end
                end
                S_RUN: begin
                    if (syn_zero) begin
                        ok_q <= 1'b1;
                    end else if (!budget_out) begin
                        word_q <= word_q ^ flip;
                        iter_q <= iter_q + ITW'(1);
                        thr_q  <= thr_nxt;
                    end
                end
                default: ;
            endcase
        end
    end

    assign out_valid  = (state == S_DONE);
    assign out_ok     = ok_q;
    assign out_word   = word_q;
    assign out_iters  = iter_q;
    assign cur_thresh = thr_q;

    // R1
    load_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (state == S_RUN && iter_q == '0 && thr_q == CW'(J) && !out_valid));

    // R4
    thr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN && !syn_zero && !budget_out && nflip == '0 && thr_q > CW'(1))
        |=> (thr_q == $past(thr_q) - CW'(1)));

    // R5
    thr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN && !syn_zero && !budget_out && nflip > NW'(FLIP_LIMIT) && thr_q < CW'(J))
        |=> (thr_q == $past(thr_q) + CW'(1)));

    // R5
    thr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_q >= CW'(1) && thr_q <= CW'(J)));

    // R7
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !accept) |=> (out_valid && $stable(out_word) && $stable(out_ok) && $stable(out_iters)));

    // R8
    ok_codeword_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ok) |-> syn_zero);

    // R8
    iter_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |-> (iter_q <= limit_q));
endmodule

// File: tb/sim_ldpc_bf_decoder.sv
module sim_ldpc_bf_decoder;
    localparam int NB = 25;
    localparam int MC = 15;
    localparam int PB = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [NB-1:0] in_word = '0;
    logic [7:0]    max_iter = 8'd20;
    logic          out_valid, out_ok;
    logic [NB-1:0] out_word;
    logic [7:0]    out_iters;
    logic [1:0]    cur_thresh;

    int n_chk = 0;
    int n_bad = 0;
    bit summary_done = 0;

    logic [NB-1:0] hrow [MC];
    logic [NB-1:0] rref [MC];
    int            piv  [MC];
    int            rank_h = 0;
    logic [NB-1:0] free_mask = '0;

    always #5 clk = ~clk;

    ldpc_bf_decoder u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .max_iter(max_iter), .out_valid(out_valid),
        .out_ok(out_ok), .out_word(out_word), .out_iters(out_iters),
        .cur_thresh(cur_thresh)
    );

    task automatic chk(input bit cond, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!cond) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [MC-1:0] syndrome(input logic [NB-1:0] w);
        logic [MC-1:0] s;
        for (int m = 0; m < MC; m++) s[m] = ^(hrow[m] & w);
        return s;
    endfunction

    // Parity-check matrix from the R2 connection rule, then reduced row echelon form
    task automatic build_code();
        for (int m = 0; m < MC; m++) hrow[m] = '0;
        for (int n = 0; n < NB; n++) begin
            int j = n / PB;
            int t = n % PB;
            for (int i = 0; i < 3; i++) hrow[i*PB + ((t + i*j) % PB)][n] = 1'b1;
        end
        for (int m = 0; m < MC; m++) rref[m] = hrow[m];
        rank_h = 0;
        for (int c = 0; c < NB && rank_h < MC; c++) begin
            int sel = -1;
            for (int r = rank_h; r < MC; r++)
                if (sel < 0 && rref[r][c]) sel = r;
            if (sel >= 0) begin
                logic [NB-1:0] tmp = rref[sel];
                rref[sel] = rref[rank_h];
                rref[rank_h] = tmp;
                for (int r = 0; r < MC; r++)
                    if (r != rank_h && rref[r][c]) rref[r] = rref[r] ^ rref[rank_h];
                piv[rank_h] = c;
                rank_h++;
            end
        end
        free_mask = '1;
        for (int r = 0; r < rank_h; r++) free_mask[piv[r]] = 1'b0;
    endtask

    function automatic logic [NB-1:0] encode(input logic [31:0] msg);
        logic [NB-1:0] c = '0;
        int k = 0;
        for (int n = 0; n < NB; n++)
            if (free_mask[n]) begin c[n] = msg[k % 32]; k++; end
        for (int r = 0; r < rank_h; r++)
            c[piv[r]] = ^(rref[r] & free_mask & c);
        return c;
    endfunction

    task automatic load(input logic [NB-1:0] w, input logic [7:0] lim);
        @(negedge clk);
        in_valid = 1'b1; in_word = w; max_iter = lim;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_done(output bit done);
        done = 0;
        for (int k = 0; k < 200 && !done; k++) begin
            if (out_valid) done = 1;
            else @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk(!out_valid && in_ready, "R1", "reset idle", {out_valid, in_ready}, 2'b01);
        chk(cur_thresh == 2'd3, "R1", "reset threshold", cur_thresh, 3);
    endtask

    task automatic t_clean();
        logic [NB-1:0] c = encode($urandom);
        bit d;
        chk(syndrome(c) == '0, "R2", "bench encoder", syndrome(c), 0);
        load(c, 8'd20);
        chk(!out_valid && out_iters == 0 && cur_thresh == 2'd3 && !in_ready,
            "R1", "state after load", {out_valid, out_iters, cur_thresh}, {1'b0, 8'd0, 2'd3});
        @(negedge clk);
        chk(out_valid && out_ok && out_iters == 0, "R2", "clean word done",
            {out_valid, out_ok, out_iters}, {2'b11, 8'd0});
        chk(out_word == c, "R2", "clean word kept", out_word, c);
        wait_done(d);
    endtask

    task automatic t_single(input int reps);
        for (int r = 0; r < reps; r++) begin
            logic [NB-1:0] c = encode($urandom);
            int e = $urandom_range(0, NB-1);
            bit d;
            load(c ^ (NB'(1) << e), 8'd20);
            wait_done(d);
            chk(d && out_ok && out_iters == 1, "R3", "single error one iteration",
                {out_ok, out_iters}, {1'b1, 8'd1});
            chk(out_word == c, "R3", "single error corrected", out_word, c);
        end
    endtask

    task automatic t_pair_drop();
        logic [NB-1:0] c = encode($urandom);
        logic [NB-1:0] w = c ^ NB'(25'h21);
        bit d;
        load(w, 8'd20);
        @(negedge clk);
        chk(!out_valid && cur_thresh == 2'd2 && out_iters == 1, "R4", "threshold lowered",
            {out_valid, cur_thresh, out_iters}, {1'b0, 2'd2, 8'd1});
        chk(out_word == w, "R4", "no bit flipped", out_word, w);
        wait_done(d);
        chk(d && out_iters <= 20, "R8", "budget respected", out_iters, 20);
        if (out_ok) chk(syndrome(out_word) == '0, "R8", "success is codeword", syndrome(out_word), 0);
        // budget of one: the lone iteration flips nothing, so the word comes back as loaded
        load(w, 8'd1);
        wait_done(d);
        chk(d && !out_ok && out_iters == 1, "R6", "budget one fails",
            {out_ok, out_iters}, {1'b0, 8'd1});
        chk(out_word == w, "R6", "failed word as is", out_word, w);
    endtask

    task automatic t_all_ones();
        bit d;
        load('1, 8'd20);
        @(negedge clk);
        chk(cur_thresh == 2'd3 && out_word == '0, "R5", "all flipped, threshold capped",
            {cur_thresh, out_word}, {2'd3, 25'd0});
        wait_done(d);
        chk(d && out_ok && out_iters == 1 && out_word == '0, "R5", "all ones decode",
            {out_ok, out_iters, out_word}, {1'b1, 8'd1, 25'd0});
    endtask

    task automatic t_zero_budget();
        logic [NB-1:0] w = encode($urandom) ^ NB'(25'h100);
        bit d;
        load(w, 8'd0);
        wait_done(d);
        chk(d && !out_ok && out_iters == 0, "R6", "zero budget fails",
            {out_ok, out_iters}, {1'b0, 8'd0});
        chk(out_word == w, "R6", "zero budget unchanged", out_word, w);
    endtask

    task automatic t_hold();
        logic [NB-1:0] w = out_word;
        logic          ok = out_ok;
        for (int k = 0; k < 5; k++) @(negedge clk);
        chk(out_valid && out_word == w && out_ok == ok && in_ready, "R7", "result held",
            {out_valid, out_ok, out_word}, {1'b1, ok, w});
    endtask

    task automatic t_multi(input int reps);
        for (int r = 0; r < reps; r++) begin
            logic [NB-1:0] c = encode($urandom);
            logic [NB-1:0] e = '0;
            int ne = $urandom_range(1, 3);
            bit d;
            while ($countones(e) < ne) e[$urandom_range(0, NB-1)] = 1'b1;
            load(c ^ e, 8'd20);
            wait_done(d);
            chk(d && out_iters <= 20, "R8", "multi budget", out_iters, 20);
            if (out_ok) begin
                chk(syndrome(out_word) == '0, "R8", "multi result codeword", syndrome(out_word), 0);
                if (ne == 1) chk(out_word == c, "R3", "multi single restored", out_word, c);
            end
        end
    endtask

    initial begin
        build_code();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean();
        t_single(8);
        t_pair_drop();
        t_all_ones();
        t_zero_budget();
        t_hold();
        t_clean();
        t_multi(60);
        if (!summary_done) begin
            summary_done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        end
        $finish;
    end

    initial begin
        #1_000_000;
        if (!summary_done) begin
            summary_done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        end
        $finish;
    end
endmodule